// File: doc/BRIEF.md
# Timed Base-Address Delay Ring

This block sits beside an offset-learning prefetcher. It takes in line addresses and hands each one back after a fixed hold time. When a prefetch is issued, the address that triggered it is pushed in. While prefetching is switched off, every L2 miss address is pushed in instead. When the hold time ends, the address comes out on the dequeue side as a write request to the left half of the recent-requests table. The hold time is set between the latency of a last-level-cache hit and the latency of a miss.

The block keeps no timestamp for each entry. The slots form a ring, and a single one-hot token walks around it, moving one slot every `STEP` cycles. Only the slot under the token is read or written. So a slot that is filled on one visit is read out on the next visit, one revolution later (`SLOTS*STEP` cycles, 60 with the defaults).

New addresses wait in a single pending register until the token next lands on a slot. If a second address arrives before the pending one has been placed, it replaces the pending one, and a saturating counter records the loss.

Top module: `line_delay_ring`

## Requirements
- R1: After a synchronous active-low reset, no slot holds an address, `deq_valid` is 0, `drop_count` is 0 and the token sits on slot 0.
- R2: The token moves one slot every `STEP` cycles, from slot k to slot (k+1) mod `SLOTS`. Slot 0 is visited at the `STEP`-th rising edge after reset is released.
- R3: An address is loaded into a slot during a visit. It appears on `deq_valid`/`deq_line` exactly `SLOTS*STEP` cycles after that load. With the defaults, an address enqueued on the first edge after reset is seen after edge 63.
- R4: An accepted enqueue is held as pending. It is placed into whichever slot the token visits next.
- R5: On a visit, the slot's stored address (if valid) is emitted first. The slot is then refilled from the pending address, or marked empty if nothing is pending. An emptied slot emits nothing on later visits.
- R6: An enqueue that arrives while another is pending, on a cycle with no visit, overwrites the pending address. It also raises `drop_count` by one. `drop_count` saturates at 2^`DROP_W`-1.
- R7: An enqueue on a visit cycle does not count as a drop. The old pending address moves into the visited slot, and the new address becomes the pending one.
- R8: `deq_valid` is high for one cycle per emitted address and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | Enqueue request |
| enq_line | input | LINE_W | Line address to delay |
| deq_valid | output | 1 | A delayed address is presented this cycle |
| deq_line | output | LINE_W | Delayed line address, the left-bank write request |
| drop_count | output | DROP_W | Saturating count of overwritten pending enqueues |

## Verification
The hardest situation to reach is an enqueue on the very cycle the token visits a slot while an older address is still pending. The old address must then go into the slot, the new one must become pending, and the drop counter must not move. The stimulus table contains bursts that enqueue on every cycle for longer than one step, so every phase of the step counter meets a pending address. A bench-side model of the ring predicts each emission cycle. A long continuous burst then drives the drop counter into saturation.

// File: rtl/dring_pkg.sv
// Shared definitions for the delay ring.
// Assumes one line width for the whole ring; the slot record carries a valid flag.
package dring_pkg;
    parameter int unsigned LINE_W = 18;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
    } slot_t;
endpackage

// File: rtl/dring_token.sv
// Step counter and one-hot token for the ring.
// Raises `visit` on the last cycle of each step; the token advances on the edge
// that ends that cycle. Assumes STEP >= 2 and SLOTS >= 2.
module dring_token #(
    parameter int unsigned SLOTS = 15,
    parameter int unsigned STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SLOTS-1:0] tok,
    output logic             visit
);
    localparam int unsigned CNT_W = (STEP > 2) ? $clog2(STEP) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP - 1);

    logic [CNT_W-1:0] cnt;

    assign visit = (cnt == CNT_LAST);

    // Count cycles within a step; wrap on the visit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (visit) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    // Rotate the token one slot upward at the end of each step.
    always_ff @(posedge clk) begin
        if (!rst_n)     tok <= SLOTS'(1);
        else if (visit) tok <= {tok[SLOTS-2:0], tok[SLOTS-1]};
    end

    assert_token_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tok) == 1);
    assert_token_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !visit |=> $stable(tok));
    assert_token_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        visit |=> tok == {$past(tok[SLOTS-2:0]), $past(tok[SLOTS-1])});
endmodule

// File: rtl/dring_hold.sv
// Single pending-enqueue register with a saturating drop counter.
// The pending entry is consumed by a visit. A fresh enqueue always wins the register.
module dring_hold
    import dring_pkg::*;
#(
    parameter int unsigned DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [LINE_W-1:0] enq_line,
    input  logic              visit,
    output slot_t             pend,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    logic lost;
    assign lost = enq_valid && pend.vld && !visit;

    // Capture new enqueues; release the pending entry when a slot takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= '0;
        else if (enq_valid) pend <= '{vld: 1'b1, line: enq_line};
        else if (visit)     pend.vld <= 1'b0;
    end

    // Count overwritten pending entries, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                             drop_count <= '0;
        else if (lost && drop_count != DROP_MAX) drop_count <= drop_count + 1'b1;
    end

    assert_enq_captured_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enq_valid |=> pend.vld && pend.line == $past(enq_line));
    assert_drop_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && pend.vld && !visit && drop_count != DROP_MAX)
        |=> drop_count == $past(drop_count) + 1'b1);
    assert_no_drop_on_visit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        visit |=> $stable(drop_count));
endmodule

// File: rtl/dring_slots.sv
// Ring storage. Only the slot selected by the one-hot token is written or read.
// On a visit the selected slot takes the pending record as is; a record with
// vld=0 leaves the slot empty. Assumes `tok` is one-hot.
module dring_slots
    import dring_pkg::*;
#(
    parameter int unsigned SLOTS = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] tok,
    input  logic             visit,
    input  slot_t            pend,
    output slot_t            head
);
    localparam int unsigned REC_W = $bits(slot_t);

    slot_t slot [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Refill or empty this slot when the token visits it.
        always_ff @(posedge clk) begin
            if (!rst_n)                slot[i] <= '0;
            else if (visit && tok[i])  slot[i] <= pend;
        end
    end

    // One-hot read mux: OR together the masked slot records.
    always_comb begin
        logic [REC_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < SLOTS; i++) begin
            acc = acc | ({REC_W{tok[i]}} & slot[i]);
        end
        head = slot_t'(acc);
    end

    assert_load_from_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && tok[0]) |=> slot[0] == $past(pend));
endmodule

// File: rtl/line_delay_ring.sv
// Delay ring top: holds each enqueued line address for SLOTS*STEP cycles and then
// presents it as a left-bank write request. Assumes the consumer accepts every
// dequeue in the cycle it is presented; there is no back-pressure.
module line_delay_ring
    import dring_pkg::*;
#(
    parameter int unsigned SLOTS  = 15,
    parameter int unsigned STEP   = 4,
    parameter int unsigned DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [LINE_W-1:0] enq_line,
    output logic              deq_valid,
    output logic [LINE_W-1:0] deq_line,
    output logic [DROP_W-1:0] drop_count
);
    logic [SLOTS-1:0] tok;
    logic             visit;
    slot_t            pend;
    slot_t            head;

    dring_token #(.SLOTS(SLOTS), .STEP(STEP)) u_token (
        .clk(clk), .rst_n(rst_n), .tok(tok), .visit(visit));

    dring_hold #(.DROP_W(DROP_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_line(enq_line),
        .visit(visit), .pend(pend), .drop_count(drop_count));

    dring_slots #(.SLOTS(SLOTS)) u_slots (
        .clk(clk), .rst_n(rst_n), .tok(tok), .visit(visit), .pend(pend), .head(head));

    // Emit the visited slot's address before it is overwritten at the edge.
    assign deq_valid = visit && head.vld;
    assign deq_line  = head.line;

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |=> !deq_valid);
endmodule

// File: tb/tb_line_delay_ring.sv
module tb_line_delay_ring;
    localparam int SLOTS = 15;
    localparam int STEP  = 4;
    localparam int DROPW = 8;
    localparam int LW    = 18;
    localparam int NVEC  = 16;
    localparam int DMAX  = (1 << DROPW) - 1;

    // Stimulus table: cycle index (from table start) and line address to enqueue.
    localparam int          VEC_CYC [NVEC] = '{0, 5, 9, 10, 11, 12, 13, 14,
                                              40, 41, 77, 78, 79, 150, 151, 152};
    localparam logic [17:0] VEC_ADR [NVEC] = '{18'h00011, 18'h3A5A5, 18'h01234, 18'h0BEEF,
                                              18'h2CAFE, 18'h1F00D, 18'h10001, 18'h3FFFF,
                                              18'h12121, 18'h21212, 18'h0AAAA, 18'h15555,
                                              18'h2DEAD, 18'h0F0F0, 18'h30303, 18'h07777};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enq_valid = 1'b0;
    logic [LW-1:0]   enq_line = '0;
    logic            deq_valid;
    logic [LW-1:0]   deq_line;
    logic [DROPW-1:0] drop_count;

    int vectors = 0;
    int misses  = 0;

    always #4 clk = ~clk;   // 125 MHz

    line_delay_ring #(.SLOTS(SLOTS), .STEP(STEP), .DROP_W(DROPW)) dut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_line(enq_line),
        .deq_valid(deq_valid), .deq_line(deq_line), .drop_count(drop_count));

    // Reference model of the requirements, advanced on every rising edge.
    int          m_tok, m_cnt, m_drop;
    logic        m_v [SLOTS];
    logic [LW-1:0] m_a [SLOTS];
    logic        m_pv;
    logic [LW-1:0] m_pa;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tok = 0; m_cnt = 0; m_drop = 0; m_pv = 0; m_pa = '0;
            for (int i = 0; i < SLOTS; i++) begin m_v[i] = 0; m_a[i] = '0; end
        end else begin
            automatic logic vis = (m_cnt == STEP - 1);
            automatic logic opv = m_pv;
            if (vis) begin
                m_v[m_tok] = opv; m_a[m_tok] = m_pa;
                m_tok = (m_tok + 1) % SLOTS;
            end
            if (enq_valid) begin
                if (opv && !vis && m_drop < DMAX) m_drop++;
                m_pv = 1; m_pa = enq_line;
            end else if (vis) m_pv = 0;
            m_cnt = vis ? 0 : m_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic ev = (m_cnt == STEP - 1) && m_v[m_tok];
            check("R5 deq_valid", 32'(deq_valid), 32'(ev));
            if (ev) check("R3 deq_line", 32'(deq_line), 32'(m_a[m_tok]));
            check("R6 drop_count", 32'(drop_count), 32'(m_drop));
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; enq_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 deq_valid in reset", 32'(deq_valid), 32'd0);
        check("R1 drop_count in reset", 32'(drop_count), 32'd0);
    endtask

    initial begin
        // Watchdog: a hang counts as a failure and still prints the summary.
        #1_000_000;
        misses++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        do_reset();

        // R3 and R1: enqueue on the first edge after release; slot 0 gets it at
        // edge STEP and emits it after edge STEP*SLOTS+STEP-1.
        rst_n = 1'b1; enq_valid = 1'b1; enq_line = 18'h2A5A5;
        n = 0;
        while (n < 200) begin
            @(negedge clk);
            enq_valid = 1'b0;
            n++;
            if (deq_valid) break;
        end
        check("R3 latency from reset", 32'(n), 32'(STEP * SLOTS + STEP - 1));
        check("R3 latency line", 32'(deq_line), 32'h2A5A5);
        // R5: the emptied slot stays silent for the next revolution.
        repeat (STEP * SLOTS) @(negedge clk);
        check("R5 emptied slot silent", 32'(deq_valid), 32'd0);

        // Table walk: bursts cover R4, R6, R7 at every step phase.
        do_reset();
        rst_n = 1'b1;
        for (int c = 0; c < 400; c++) begin
            enq_valid = 1'b0;
            for (int k = 0; k < NVEC; k++) begin
                if (VEC_CYC[k] == c) begin enq_valid = 1'b1; enq_line = VEC_ADR[k]; end
            end
            @(negedge clk);
        end
        enq_valid = 1'b0;

        // R6: continuous enqueue drives the drop counter into saturation.
        for (int c = 0; c < 600; c++) begin
            enq_valid = 1'b1; enq_line = LW'(c * 37 + 5);
            @(negedge clk);
        end
        enq_valid = 1'b0;
        check("R6 drop_count saturated", 32'(drop_count), 32'(DMAX));
        repeat (2 * STEP * SLOTS) @(negedge clk);

        // R1: a mid-run reset empties every slot; nothing emerges afterwards.
        enq_valid = 1'b1; enq_line = 18'h00F0F;
        @(negedge clk);
        do_reset();
        rst_n = 1'b1;
        n = 0;
        for (int c = 0; c < 3 * STEP * SLOTS; c++) begin
            @(negedge clk);
            if (deq_valid) n++;
        end
        check("R1 no output after reset", 32'(n), 32'd0);
        check("R1 drop_count after reset", 32'(drop_count), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule